// File: doc/BRIEF.md
# Timeslot-Gated HDLC Transmitter

This block feeds a bit-serial E1 transmit stream. Each frame of the stream has 32 timeslots of 8 bits. A 32-bit mask selects which timeslots carry the controller's own bits. In every other timeslot the system data on the serial input passes straight to the output. The controller takes bytes from a 64-byte transmit queue and builds HDLC frames from them. Each frame gets an opening flag, the payload with zero insertion, a 16-bit frame check sequence and a closing flag. Between frames the controller sends an 8-bit idle pattern chosen by the user.

The controller's bit engine moves forward only during the bit times of enabled timeslots. It keeps its whole state, including the run of ones and the checksum, across disabled timeslots. A frame can therefore spread over scattered timeslots and over many E1 frames. A transparent mode sends queued bytes as they are, with no framing. A repeat mode keeps resending the queue contents and does not drain them.

Software writes bytes one per clock. A strobe on the last byte of a frame marks where that frame ends. The full and level outputs report how much the queue holds. The block also outputs its own timeslot and bit position, so the surrounding logic can line up the system data.

Top module: `hdlc_ts_tx`

## Requirements
- R1: After reset `ts_cnt` and `bit_cnt` read 0. `bit_cnt` increments every clock. When it leaves 7 it returns to 0 and `ts_cnt` increments, and `ts_cnt` wraps from 31 to 0.
- R2: Bit i of `ts_mask` enables timeslot i. While the current timeslot is disabled, `tx_out` equals `sys_in`. While it is enabled, `tx_out` carries the controller bit.
- R3: The queue holds 64 entries. `fifo_level` gives the count and `fifo_full` is high at 64. A write made while the queue is full is dropped and leaves the queue contents unchanged.
- R4: In HDLC mode a frame starts at a byte boundary once the queue is non-empty. It is sent as a 0x7E flag, then the payload bytes least significant bit first, then the check sequence, then a 0x7E flag. The byte written with `wr_last`=1 is the final payload byte.
- R5: The check sequence uses the generator x^16+x^12+x^5+1, preset to 0xFFFF. It is sent complemented, low byte first, each byte least significant bit first. The payload bytes 0x31..0x39 yield the trailer bytes 0x6E, 0x90. A receiver that runs its checksum over the payload and trailer together ends at 0xF0B8.
- R6: After five consecutive ones in the payload or the check sequence, a zero is inserted.
- R7: While no frame is pending, `idle_code` is loaded at every byte boundary and sent without zero insertion.
- R8: The bit engine advances only in enabled timeslots. Frames stay intact when the enabled timeslots are not adjacent.
- R9: If the queue runs empty inside a frame before the final byte, the engine sends eight ones (an abort) and then goes back to idle.
- R10: With `transparent_en`=1, queued bytes are sent least significant bit first, with no flags, no check sequence and no zero insertion. `idle_code` fills the gaps.
- R11: With `continuous_en`=1, reads do not free entries and `fifo_level` stays constant. After the newest entry the read position returns to the oldest. In HDLC mode each pass through the queue is one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one stream bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for one queue byte |
| wr_data | input | 8 | Byte to queue |
| wr_last | input | 1 | Marks the written byte as the end of a frame |
| fifo_full | output | 1 | Queue holds 64 entries |
| fifo_level | output | 7 | Number of queued entries |
| transparent_en | input | 1 | Send raw bytes without HDLC framing |
| continuous_en | input | 1 | Resend the queue contents without draining them |
| idle_code | input | 8 | Pattern sent between frames |
| ts_mask | input | 32 | Per-timeslot enable for controller insertion |
| sys_in | input | 1 | Serial system data |
| tx_out | output | 1 | Serial output stream |
| ts_cnt | output | 5 | Current timeslot |
| bit_cnt | output | 3 | Current bit within the timeslot |

## Verification
The bench uses the default parameters: a 64-entry queue and 32 timeslots of 8 bits. With these values the full flag and the dropped 65th write can be reached within a few dozen cycles. The timeslot wrap from 31 to 0 occurs every 256 cycles, so both the counter wrap and frames split over three timeslots spread across several E1 frames can be observed in a short run. The bench decodes the enabled-timeslot bits as a receiver would. It removes the inserted zeros, detects flags and aborts, and checks each frame's check-sequence residue.

// File: rtl/hdlc_tx_pkg.sv
// Shared types and constants for the timeslot-gated HDLC transmitter.
package hdlc_tx_pkg;

    // Engine states; RAW carries a transparent-mode byte.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_DATA,
        ST_FCS_LO,
        ST_FCS_HI,
        ST_CLOSE,
        ST_ABORT,
        ST_RAW
    } tx_state_e;

    localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
    localparam logic [7:0]  ABORT_BYTE = 8'hFF;
    localparam logic [15:0] CRC_PRESET = 16'hFFFF;
    // Bit-reversed form of x^16+x^12+x^5+1 for an LSB-first shift.
    localparam logic [15:0] CRC_POLY_R = 16'h8408;
    localparam int          STUFF_RUN  = 5;

endpackage

// File: rtl/hdlc_tx_fifo.sv
// Byte queue with a frame-end tag per entry.
// Assumes DEPTH is a power of two so pointers wrap naturally.
// In repeat mode a separate read position walks the entries without freeing
// them and returns to the oldest entry after the newest one.
module hdlc_tx_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cont,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          pop,
    output logic [W-1:0]  rd_data,
    output logic          pass_end,
    output logic          avail,
    output logic          full,
    output logic [LW-1:0] level
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q, pk_q;
    logic          wr_ok, pop_ok, drain, wrap;

    assign full     = (level == LW'(DEPTH));
    assign avail    = (level != '0);
    assign wr_ok    = wr_en && !full;
    assign pop_ok   = pop && avail;
    assign drain    = pop_ok && !cont;
    assign wrap     = (pk_q + AW'(1)) == wr_q;
    assign pass_end = cont && wrap;
    assign rd_data  = mem[cont ? pk_q : rd_q];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_q] <= wr_data;
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            pk_q  <= '0;
            level <= '0;
        end else begin
            if (wr_ok) wr_q <= wr_q + AW'(1);
            if (drain) rd_q <= rd_q + AW'(1);
            if (!cont)       pk_q <= drain ? rd_q + AW'(1) : rd_q;
            else if (pop_ok) pk_q <= wrap ? rd_q : pk_q + AW'(1);
            case ({wr_ok, drain})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/ts_bit_counter.sv
// Free-running position counter: bit within timeslot, then timeslot.
// Assumes the stream carries one bit per clock.
module ts_bit_counter #(
    parameter int NUM_TS  = 32,
    parameter int TS_BITS = 8,
    localparam int TW     = $clog2(NUM_TS),
    localparam int BW     = $clog2(TS_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [TW-1:0] ts,
    output logic [BW-1:0] bitpos
);

    // Advance bit position, carrying into the timeslot index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts     <= '0;
            bitpos <= '0;
        end else if (bitpos == BW'(TS_BITS - 1)) begin
            bitpos <= '0;
            ts     <= (ts == TW'(NUM_TS - 1)) ? '0 : ts + TW'(1);
        end else begin
            bitpos <= bitpos + BW'(1);
        end
    end

endmodule

// File: rtl/hdlc_tx_engine.sv
// Bit-serial HDLC framer: flags, payload, checksum trailer, zero insertion,
// abort on underrun, idle fill and a raw transparent path.
// Assumes adv is high only in enabled bit times; all state holds otherwise.
module hdlc_tx_engine
    import hdlc_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adv,
    input  logic       transparent,
    input  logic [7:0] idle_code,
    input  logic       fifo_avail,
    input  logic [7:0] fifo_byte,
    input  logic       fifo_last,
    output logic       pop,
    output logic       out_bit,
    output logic       stuff_zone,
    output logic       abort_now
);

    tx_state_e   state_q, nstate;
    logic [7:0]  sh_q, nsh;
    logic [2:0]  cnt_q;
    logic [2:0]  ones_q;
    logic        stuff_q, last_q, nlast, take;
    logic [15:0] crc_q, crc_nxt;
    logic        in_zone, byte_end;

    assign in_zone    = (state_q == ST_DATA) || (state_q == ST_FCS_LO) || (state_q == ST_FCS_HI);
    assign out_bit    = stuff_q ? 1'b0 : sh_q[0];
    assign stuff_zone = stuff_q || in_zone;
    assign abort_now  = (state_q == ST_ABORT);
    assign crc_nxt    = (crc_q >> 1) ^ ((crc_q[0] ^ sh_q[0]) ? CRC_POLY_R : 16'h0000);
    assign byte_end   = adv && !stuff_q && (cnt_q == 3'd7);
    assign pop        = byte_end && take;

    // Choose the byte and state that follow the current byte.
    always_comb begin
        take   = 1'b0;
        nstate = state_q;
        nsh    = idle_code;
        nlast  = last_q;
        case (state_q)
            ST_OPEN: begin
                if (fifo_avail) begin
                    take = 1'b1; nsh = fifo_byte; nlast = fifo_last; nstate = ST_DATA;
                end else begin
                    nsh = ABORT_BYTE; nstate = ST_ABORT;
                end
            end
            ST_DATA: begin
                if (last_q) begin
                    nsh = ~crc_nxt[7:0]; nstate = ST_FCS_LO;
                end else if (fifo_avail) begin
                    take = 1'b1; nsh = fifo_byte; nlast = fifo_last;
                end else begin
                    nsh = ABORT_BYTE; nstate = ST_ABORT;
                end
            end
            ST_FCS_LO: begin
                nsh = ~crc_q[15:8]; nstate = ST_FCS_HI;
            end
            ST_FCS_HI: begin
                nsh = FLAG_BYTE; nstate = ST_CLOSE;
            end
            default: begin
                if (transparent && fifo_avail) begin
                    take = 1'b1; nsh = fifo_byte; nstate = ST_RAW;
                end else if (!transparent && fifo_avail) begin
                    nsh = FLAG_BYTE; nstate = ST_OPEN;
                end else begin
                    nsh = idle_code; nstate = ST_IDLE;
                end
            end
        endcase
    end

    // Shift one bit per enabled bit time; insert zeros; load bytes at boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sh_q    <= FLAG_BYTE;
            cnt_q   <= '0;
            ones_q  <= '0;
            stuff_q <= 1'b0;
            last_q  <= 1'b0;
            crc_q   <= CRC_PRESET;
        end else if (adv) begin
            if (stuff_q) begin
                stuff_q <= 1'b0;
            end else begin
                if (in_zone && sh_q[0]) begin
                    if (ones_q == 3'(STUFF_RUN - 1)) begin
                        stuff_q <= 1'b1;
                        ones_q  <= '0;
                    end else begin
                        ones_q <= ones_q + 3'd1;
                    end
                end else begin
                    ones_q <= '0;
                end
                if (state_q == ST_DATA) crc_q <= crc_nxt;
                if (cnt_q == 3'd7) begin
                    sh_q    <= nsh;
                    state_q <= nstate;
                    last_q  <= nlast;
                    cnt_q   <= '0;
                    if (nstate == ST_OPEN) crc_q <= CRC_PRESET;
                end else begin
                    sh_q  <= sh_q >> 1;
                    cnt_q <= cnt_q + 3'd1;
                end
            end
        end
    end

endmodule

// File: rtl/hdlc_ts_tx.sv
// Top: merges controller bits into enabled timeslots of the serial stream.
// Assumes one stream bit per clock and a 64-entry power-of-two queue.
module hdlc_ts_tx #(
    parameter int FIFO_DEPTH = 64,
    parameter int NUM_TS     = 32,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
    localparam int TS_W      = $clog2(NUM_TS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              wr_last,
    output logic              fifo_full,
    output logic [LVL_W-1:0]  fifo_level,
    input  logic              transparent_en,
    input  logic              continuous_en,
    input  logic [7:0]        idle_code,
    input  logic [NUM_TS-1:0] ts_mask,
    input  logic              sys_in,
    output logic              tx_out,
    output logic [TS_W-1:0]   ts_cnt,
    output logic [2:0]        bit_cnt
);

    logic       adv, fifo_pop, fifo_avail, pass_end;
    logic       eng_bit, stuff_zone, abort_now;
    logic [8:0] rd_entry;

    // Controller owns the bit only in enabled timeslots.
    assign adv    = ts_mask[ts_cnt];
    assign tx_out = adv ? eng_bit : sys_in;

    ts_bit_counter #(.NUM_TS(NUM_TS), .TS_BITS(8)) u_pos (
        .clk(clk), .rst_n(rst_n), .ts(ts_cnt), .bitpos(bit_cnt)
    );

    hdlc_tx_fifo #(.DEPTH(FIFO_DEPTH), .W(9)) u_fifo (
        .clk(clk), .rst_n(rst_n), .cont(continuous_en),
        .wr_en(wr_en), .wr_data({wr_last, wr_data}), .pop(fifo_pop),
        .rd_data(rd_entry), .pass_end(pass_end), .avail(fifo_avail),
        .full(fifo_full), .level(fifo_level)
    );

    hdlc_tx_engine u_eng (
        .clk(clk), .rst_n(rst_n), .adv(adv), .transparent(transparent_en),
        .idle_code(idle_code), .fifo_avail(fifo_avail),
        .fifo_byte(rd_entry[7:0]), .fifo_last(rd_entry[8] | pass_end),
        .pop(fifo_pop), .out_bit(eng_bit), .stuff_zone(stuff_zone),
        .abort_now(abort_now)
    );

endmodule

// File: rtl/hdlc_ts_tx_chk.sv
// Property checker for hdlc_ts_tx, attached by bind below.
module hdlc_ts_tx_chk #(
    parameter int NUM_TS = 32,
    parameter int LVL_W  = 7,
    parameter int TS_W   = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             fifo_full,
    input logic [LVL_W-1:0] fifo_level,
    input logic             fifo_pop,
    input logic             continuous_en,
    input logic [TS_W-1:0]  ts_cnt,
    input logic [2:0]       bit_cnt,
    input logic             adv,
    input logic             eng_bit,
    input logic             stuff_zone,
    input logic             abort_now
);

    logic [2:0] run_q;

    // Count consecutive ones sent where zero insertion applies.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else if (adv) run_q <= (stuff_zone && eng_bit) ? ((run_q == 3'd7) ? run_q : run_q + 3'd1) : 3'd0;
    end

    p_ts_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt == 3'd7 && ts_cnt == TS_W'(NUM_TS - 1)) |=> (ts_cnt == '0 && bit_cnt == 3'd0));

    p_bit_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt != 3'd7) |=> (bit_cnt == $past(bit_cnt) + 3'd1 && $stable(ts_cnt)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && wr_en && !fifo_pop) |=> $stable(fifo_level));

    p_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && !wr_en && !continuous_en && fifo_level != '0) |=> (fifo_level == $past(fifo_level) - LVL_W'(1)));

    p_stuff_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && stuff_zone && eng_bit) |-> (run_q < 3'd5));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !wr_en) |=> ($stable(eng_bit) && $stable(fifo_level)));

    p_abort_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_now && adv && !stuff_zone) |-> eng_bit);

    p_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (continuous_en && !wr_en) |=> $stable(fifo_level));

endmodule

bind hdlc_ts_tx hdlc_ts_tx_chk #(.NUM_TS(NUM_TS), .LVL_W(LVL_W), .TS_W(TS_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .fifo_full(fifo_full),
    .fifo_level(fifo_level), .fifo_pop(fifo_pop), .continuous_en(continuous_en),
    .ts_cnt(ts_cnt), .bit_cnt(bit_cnt), .adv(adv), .eng_bit(eng_bit),
    .stuff_zone(stuff_zone), .abort_now(abort_now)
);

// File: tb/test_hdlc_ts_tx.sv
// Directed bench: one task per scenario; 20-unit period stands for 50 MHz.
module test_hdlc_ts_tx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        wr_last = 1'b0;
    logic        fifo_full;
    logic [6:0]  fifo_level;
    logic        transparent_en = 1'b0;
    logic        continuous_en = 1'b0;
    logic [7:0]  idle_code = 8'h7E;
    logic [31:0] ts_mask = '0;
    logic        sys_in = 1'b0;
    logic        tx_out;
    logic [4:0]  ts_cnt;
    logic [2:0]  bit_cnt;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    hdlc_ts_tx i_hdlc_ts_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last),
        .fifo_full(fifo_full), .fifo_level(fifo_level), .transparent_en(transparent_en),
        .continuous_en(continuous_en), .idle_code(idle_code), .ts_mask(ts_mask),
        .sys_in(sys_in), .tx_out(tx_out), .ts_cnt(ts_cnt), .bit_cnt(bit_cnt)
    );

    always #10 clk = ~clk;

    // Captured enabled-timeslot bits since the last reset.
    logic       cap [8192];
    int         ncap;
    logic [4:0] prev_ts;
    logic [2:0] prev_bit;
    bit         have_prev;
    logic [15:0] lfsr = 16'hACE1;

    // Decoder results.
    logic       bb [2048];
    logic [7:0] frb [8][64];
    int         frn [8];
    int         nfr;
    int         naborts;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: counter stepping (R1), pass-through (R2) and capture.
    always @(negedge clk) begin
        if (!rst_n) begin
            ncap = 0;
            have_prev = 0;
        end else begin
            if (have_prev) begin
                if (prev_bit == 3'd7)
                    check(bit_cnt == 3'd0 && ts_cnt == prev_ts + 5'd1, "R1 wrap", {ts_cnt, bit_cnt}, {prev_ts + 5'd1, 3'd0});
                else
                    check(bit_cnt == prev_bit + 3'd1 && ts_cnt == prev_ts, "R1 step", {ts_cnt, bit_cnt}, {prev_ts, prev_bit + 3'd1});
            end
            have_prev = 1;
            prev_ts = ts_cnt;
            prev_bit = bit_cnt;
            if (ts_mask[ts_cnt]) begin
                if (ncap < 8192) cap[ncap] = tx_out;
                ncap++;
            end else begin
                check(tx_out == sys_in, "R2 pass-through", tx_out, sys_in);
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sys_in = lfsr[0];
        end
    end

    task automatic do_reset(input bit tr, input bit ct, input logic [7:0] idle, input logic [31:0] mask);
        @(posedge clk); #1;
        rst_n = 1'b0;
        transparent_en = tr;
        continuous_en = ct;
        idle_code = idle;
        ts_mask = mask;
        wr_en = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic write_byte(input logic [7:0] d, input bit last);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = d; wr_last = last;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_last = 1'b0;
    endtask

    task automatic set_mask(input logic [31:0] m);
        @(posedge clk); #1 ts_mask = m;
    endtask

    function automatic logic [15:0] crc_over(input int f, input int n);
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < n; k++)
            for (int j = 0; j < 8; j++)
                c = (c >> 1) ^ ((c[0] ^ frb[f][k][j]) ? 16'h8408 : 16'h0000);
        return c;
    endfunction

    // Receiver model: removes inserted zeros, finds flags and aborts.
    task automatic decode();
        int ones = 0;
        int nb = 0;
        bit inframe = 0;
        int lim;
        nfr = 0;
        naborts = 0;
        lim = (ncap < 8192) ? ncap : 8192;
        for (int i = 0; i < lim; i++) begin
            if (cap[i]) begin
                ones++;
                if (ones == 7) begin
                    if (inframe) naborts++;
                    inframe = 0;
                end
                if (inframe && nb < 2048) begin bb[nb] = 1'b1; nb++; end
            end else begin
                if (ones == 5 && inframe) begin
                    ones = 0;
                end else if (ones == 6) begin
                    if (inframe && nb - 7 >= 24 && (nb - 7) % 8 == 0) begin
                        if (nfr < 8) begin
                            frn[nfr] = (nb - 7) / 8;
                            for (int k = 0; k < frn[nfr] && k < 64; k++)
                                for (int j = 0; j < 8; j++)
                                    frb[nfr][k][j] = bb[k * 8 + j];
                        end
                        nfr++;
                    end
                    inframe = 1; nb = 0; ones = 0;
                end else if (ones >= 7) begin
                    ones = 0;
                end else begin
                    ones = 0;
                    if (inframe && nb < 2048) begin bb[nb] = 1'b0; nb++; end
                end
            end
        end
    endtask

    function automatic logic [7:0] cap_byte(input int k);
        logic [7:0] b;
        for (int j = 0; j < 8; j++) b[j] = cap[k * 8 + j];
        return b;
    endfunction

    // First captured byte that is neither the reset flag nor the idle code.
    function automatic int first_data(input logic [7:0] idle);
        for (int k = 0; k < ncap / 8; k++)
            if (cap_byte(k) != 8'h7E && cap_byte(k) != idle) return k;
        return -1;
    endfunction

    task automatic t_reset();
        do_reset(0, 0, 8'h7E, 32'h0);
        @(negedge clk);
        check(ts_cnt == 0 && bit_cnt == 0, "R1 reset position", {ts_cnt, bit_cnt}, 0);
        check(fifo_level == 0 && !fifo_full, "R3 reset empty", fifo_level, 0);
        repeat (600) @(posedge clk);
    endtask

    task automatic t_fcs_known();
        do_reset(0, 0, 8'h7E, 32'h0);
        for (int i = 0; i < 9; i++) write_byte(8'h31 + 8'(i), i == 8);
        set_mask(32'hFFFF_FFFF);
        repeat (400) @(posedge clk);
        decode();
        check(nfr == 1, "R4 one frame", nfr, 1);
        check(frn[0] == 11, "R4 frame length", frn[0], 11);
        for (int i = 0; i < 9; i++) check(frb[0][i] == 8'h31 + 8'(i), "R4 payload", frb[0][i], 8'h31 + 8'(i));
        check(frb[0][9] == 8'h6E && frb[0][10] == 8'h90, "R5 trailer", {frb[0][10], frb[0][9]}, 16'h906E);
        check(crc_over(0, 11) == 16'hF0B8, "R5 residue", crc_over(0, 11), 16'hF0B8);
        check(naborts == 0, "R4 no abort", naborts, 0);
    endtask

    task automatic t_stuffing();
        logic [7:0] d [5] = '{8'hFF, 8'hFF, 8'h7E, 8'h3F, 8'hF8};
        int zeros_needed;
        do_reset(0, 0, 8'h7E, 32'h0);
        for (int i = 0; i < 5; i++) write_byte(d[i], i == 4);
        set_mask(32'hFFFF_FFFF);
        repeat (400) @(posedge clk);
        decode();
        check(nfr == 1 && naborts == 0, "R6 frame survives ones", nfr, 1);
        for (int i = 0; i < 5; i++) check(frb[0][i] == d[i], "R6 payload after removal", frb[0][i], d[i]);
        check(crc_over(0, 7) == 16'hF0B8, "R6 residue", crc_over(0, 7), 16'hF0B8);
        zeros_needed = ncap;
        check(zeros_needed > 0, "R6 capture", zeros_needed, 1);
    endtask

    task automatic t_sparse();
        logic [7:0] d [5] = '{8'hA5, 8'h00, 8'hFF, 8'h81, 8'h5A};
        do_reset(0, 0, 8'h7E, 32'h0);
        for (int i = 0; i < 5; i++) write_byte(d[i], i == 4);
        set_mask(32'h0002_0022);
        repeat (2000) @(posedge clk);
        decode();
        check(nfr == 1, "R8 frame over scattered timeslots", nfr, 1);
        for (int i = 0; i < 5; i++) check(frb[0][i] == d[i], "R8 payload", frb[0][i], d[i]);
        check(crc_over(0, 7) == 16'hF0B8, "R8 residue", crc_over(0, 7), 16'hF0B8);
        check(fifo_level == 0, "R8 drained", fifo_level, 0);
    endtask

    task automatic t_idle();
        int zeros = 0;
        do_reset(0, 0, 8'hFF, 32'hFFFF_FFFF);
        repeat (300) @(posedge clk);
        for (int i = 8; i < ncap && i < 8192; i++) if (!cap[i]) zeros++;
        check(zeros == 0, "R7 idle ones not stuffed", zeros, 0);
        write_byte(8'h42, 1);
        repeat (200) @(posedge clk);
        decode();
        check(nfr == 1 && frb[0][0] == 8'h42, "R7 frame after idle", frb[0][0], 8'h42);
    endtask

    task automatic t_abort();
        do_reset(0, 0, 8'h7E, 32'h0);
        write_byte(8'h12, 0);
        write_byte(8'h34, 0);
        set_mask(32'hFFFF_FFFF);
        repeat (200) @(posedge clk);
        decode();
        check(naborts >= 1, "R9 abort seen", naborts, 1);
        check(nfr == 0, "R9 no frame delivered", nfr, 0);
        write_byte(8'h5A, 1);
        repeat (200) @(posedge clk);
        decode();
        check(nfr == 1 && frb[0][0] == 8'h5A, "R9 idle then next frame", frb[0][0], 8'h5A);
    endtask

    task automatic t_transparent();
        logic [7:0] d [4] = '{8'h01, 8'h80, 8'h3C, 8'hE7};
        int s;
        do_reset(1, 0, 8'hAA, 32'h0);
        for (int i = 0; i < 4; i++) write_byte(d[i], 0);
        set_mask(32'hFFFF_FFFF);
        repeat (300) @(posedge clk);
        s = first_data(8'hAA);
        check(s >= 0, "R10 data found", s, 0);
        for (int i = 0; i < 4; i++) check(cap_byte(s + i) == d[i], "R10 raw byte", cap_byte(s + i), d[i]);
        check(cap_byte(s + 4) == 8'hAA, "R10 idle fill", cap_byte(s + 4), 8'hAA);
    endtask

    task automatic t_full();
        int s;
        do_reset(1, 0, 8'hAA, 32'h0);
        for (int i = 0; i < 64; i++) write_byte(8'(i), 0);
        check(fifo_full && fifo_level == 64, "R3 full at 64", fifo_level, 64);
        write_byte(8'hC3, 0);
        check(fifo_level == 64, "R3 extra write dropped", fifo_level, 64);
        set_mask(32'hFFFF_FFFF);
        repeat (64 * 8 + 100) @(posedge clk);
        check(fifo_level == 0 && !fifo_full, "R3 drained", fifo_level, 0);
        s = first_data(8'hAA);
        for (int i = 0; i < 64; i++) check(cap_byte(s + i) == 8'(i), "R3 order kept", cap_byte(s + i), i);
        check(cap_byte(s + 64) == 8'hAA, "R3 dropped byte absent", cap_byte(s + 64), 8'hAA);
    endtask

    task automatic t_cont_hdlc();
        do_reset(0, 1, 8'h7E, 32'h0);
        write_byte(8'hC0, 0);
        write_byte(8'hDE, 0);
        write_byte(8'h77, 1);
        set_mask(32'hFFFF_FFFF);
        repeat (600) @(posedge clk);
        decode();
        check(nfr >= 3, "R11 repeated frames", nfr, 3);
        for (int f = 0; f < 3; f++)
            check(frn[f] == 5 && frb[f][0] == 8'hC0 && frb[f][2] == 8'h77, "R11 each pass", frb[f][2], 8'h77);
        check(fifo_level == 3, "R11 not drained", fifo_level, 3);
    endtask

    task automatic t_cont_raw();
        int s;
        do_reset(1, 1, 8'hAA, 32'h0);
        write_byte(8'h11, 0);
        write_byte(8'h22, 0);
        set_mask(32'hFFFF_FFFF);
        repeat (200) @(posedge clk);
        s = first_data(8'hAA);
        for (int i = 0; i < 6; i++)
            check(cap_byte(s + i) == ((i % 2 == 0) ? 8'h11 : 8'h22), "R11 raw repeat", cap_byte(s + i), (i % 2 == 0) ? 8'h11 : 8'h22);
        check(fifo_level == 2, "R11 raw level kept", fifo_level, 2);
    endtask

    initial begin
        t_reset();
        t_fcs_known();
        t_stuffing();
        t_sparse();
        t_idle();
        t_abort();
        t_transparent();
        t_full();
        t_cont_hdlc();
        t_cont_raw();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule